// File: doc/BRIEF.md
# Two-Pin External Interrupt Controller

This block watches two external interrupt pins and turns activity on them into an interrupt request for a CPU. Each pin has its own two-bit sense mode: low level, any change, falling edge or rising edge. Each pin input is resynchronised into the clock domain, and its edges are found by comparing successive samples. When a pin's selected edge condition occurs, the matching pending flag latches. Software clears a flag by writing a one to it.

A pin raises a request when three things hold together: the global interrupt enable input is high, the pin's enable bit is set, and the pin is pending. In low-level mode the pin counts as pending for as long as it stays low. No flag is latched in that mode. When both pins request, pin 0 is presented first. An acknowledge pulse from the CPU clears the flag of the pin being presented.

The pins are plain inputs. Software can therefore raise an interrupt by driving a pin that it also uses as an output. Registers are reached over a simple synchronous bus. Writes take effect on the clock edge. Reads are combinational.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the sense register (address 0), enable register (address 1) and pending register (address 2) all read 0x00, and irq_o is low.
- R2: With pin n's sense field (bits 2n+1:2n of address 0) set to 2'b11, a rising edge on pin n sets pending bit n, and a falling edge does not.
- R3: With sense field 2'b10, a falling edge sets pending bit n, and a rising edge does not.
- R4: With sense field 2'b01, both rising and falling edges set pending bit n.
- R5: With sense field 2'b00, no pending bit is latched. Pin n requests an interrupt while its synchronised input is low and its enable is set, and stops when the pin goes high.
- R6: Writing address 2 clears each pending bit written with one. Bits written with zero are unchanged.
- R7: Enable register bits 7:2 and pending register bits 7:2 always read zero. Writes cannot set them, and writes to address 2 never set a pending bit.
- R8: irq_o is high only when gie_i is high, the pin's enable bit (bit n of address 1) is set, and the pin is pending.
- R9: When both pins request, irq_id_o presents pin 0.
- R10: If a pin event and a write-one-to-clear of the same flag occur in the same cycle, the flag ends up set.
- R11: An ack_i pulse while irq_o is high clears only the pending bit of the pin shown on irq_id_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 2 | External interrupt pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| ack_i | input | 1 | One-cycle acknowledge of the presented interrupt |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_id_o | output | 1 | Index of the pin being presented |

## Verification
The bench drives each sense mode with both edge directions.
- A detector that confuses rise and fall latches on the wrong edge.
- A low-level path that latches a flag keeps requesting after the pin returns high.

The bench writes zeros to pending bits. A clear that ignores the data value wipes flags it should keep. It also lines up a write-one-to-clear with the exact cycle in which an edge lands. A design where the clear wins loses that event.

With both pins pending, the bench acknowledges twice. A wrong priority or a clear aimed at the wrong pin shows up as the wrong id or a wrong leftover flag. Toggling the global enable with flags already set exposes missing gating.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam int unsigned ADDR_SENSE   = 0;
   localparam int unsigned ADDR_ENABLE  = 1;
   localparam int unsigned ADDR_PENDING = 2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ext_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
   import ext_irq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin_s,
   input  sense_e mode,
   input  logic   clr_i,
   output logic   flag_o,
   output logic   level_o
);
   logic prev_q;
   logic flag_q;
   logic evt;

   always_comb begin
      unique case (mode)
         SENSE_ANY:  evt = pin_s ^ prev_q;
         SENSE_FALL: evt = prev_q & ~pin_s;
         SENSE_RISE: evt = ~prev_q & pin_s;
         default:    evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= pin_s;
         if (evt)        flag_q <= 1'b1;
         else if (clr_i) flag_q <= 1'b0;
      end
   end

   assign flag_o  = flag_q;
   assign level_o = (mode == SENSE_LOW) & ~pin_s;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag_q); // R10
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt) |=> !flag_q); // R6
   AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SENSE_LOW && !flag_q) |=> !flag_q); // R5
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb #(
   parameter int unsigned N   = 2,
   localparam int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   req_i,
   output logic           any_o,
   output logic [IDW-1:0] id_o
);
   always_comb begin
      id_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) id_o = IDW'(i);
      end
   end

   assign any_o = |req_i;

   AST_PIN0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[0] |-> (id_o == '0)); // R9
   AST_ID_REQUESTING: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> req_i[id_o]); // R9
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SENSE_W    = 2 * NUM_PINS,
   localparam int unsigned IDW        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                gie_i,
   input  logic                ack_i,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_we,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_o,
   output logic [IDW-1:0]      irq_id_o
);
   generate
      if (SENSE_W > DATA_W) begin : g_bad_width
         $error("ext_irq_ctrl: sense fields do not fit in DATA_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ext_irq_ctrl: ADDR_W must be at least 2");
      end
      if (SENSE_W < DATA_W) begin : g_spare
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SENSE_W];
      end
   endgenerate

   logic [SENSE_W-1:0]  sense_q;
   logic [NUM_PINS-1:0] enable_q;
   logic [NUM_PINS-1:0] pin_s;
   logic [NUM_PINS-1:0] flag;
   logic [NUM_PINS-1:0] level;
   logic [NUM_PINS-1:0] req;
   logic [NUM_PINS-1:0] clr;
   logic [NUM_PINS-1:0] w1c;
   logic [NUM_PINS-1:0] ack_clr;

   wire sel_sense   = (bus_addr == ADDR_W'(ADDR_SENSE));
   wire sel_enable  = (bus_addr == ADDR_W'(ADDR_ENABLE));
   wire sel_pending = (bus_addr == ADDR_W'(ADDR_PENDING));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q  <= '0;
         enable_q <= '0;
      end else if (bus_we) begin
         if (sel_sense)  sense_q  <= bus_wdata[SENSE_W-1:0];
         if (sel_enable) enable_q <= bus_wdata[NUM_PINS-1:0];
      end
   end

   assign w1c     = (bus_we && sel_pending) ? bus_wdata[NUM_PINS-1:0] : '0;
   assign ack_clr = (ack_i && irq_o) ? (NUM_PINS'(1) << irq_id_o) : '0;
   assign clr     = w1c | ack_clr;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pin_i[g]),
         .q_o   (pin_s[g])
      );

      ext_irq_detect u_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_s   (pin_s[g]),
         .mode    (sense_e'(sense_q[2*g+1 -: 2])),
         .clr_i   (clr[g]),
         .flag_o  (flag[g]),
         .level_o (level[g])
      );

      assign req[g] = gie_i & enable_q[g] & (flag[g] | level[g]);
   end

   ext_irq_arb #(.N(NUM_PINS)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req),
      .any_o (irq_o),
      .id_o  (irq_id_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (sel_sense)        bus_rdata[SENSE_W-1:0]  = sense_q;
      else if (sel_enable)  bus_rdata[NUM_PINS-1:0] = enable_q;
      else if (sel_pending) bus_rdata[NUM_PINS-1:0] = flag;
   end

   AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> gie_i); // R8
   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> enable_q[irq_id_o]); // R8
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_enable || sel_pending) |-> (bus_rdata[DATA_W-1:NUM_PINS] == '0)); // R7
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && !irq_id_o[0] && !w1c[1]) |=> (flag[1] == $past(flag[1]) || flag[1])); // R11
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pin_i = 2'b00;
   logic       gie_i = 1'b0;
   logic       ack_i = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic       irq_o;
   logic [0:0] irq_id_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      string      tag;
      bit         is_irq;
      logic [7:0] exp;
   } item_t;
   item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_irq_ctrl u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin_i),
      .gie_i     (gie_i),
      .ack_i     (ack_i),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .irq_id_o  (irq_id_o)
   );

   // monitor: pops expected items and compares with the observed ports
   initial begin
      forever begin
         item_t it;
         logic [7:0] act;
         wait (sb.size() != 0);
         it = sb.pop_front();
         act = it.is_irq ? {6'd0, irq_id_o, irq_o} : bus_rdata;
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
         end
      end
   end

   task automatic push(input string tag, input bit is_irq, input logic [7:0] exp);
      item_t it;
      it.tag = tag; it.is_irq = is_irq; it.exp = exp;
      sb.push_back(it);
      wait (sb.size() == 0);
   endtask

   task automatic chk_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      push(tag, 1'b0, exp);
   endtask

   // expected {id, irq}
   task automatic chk_irq(input string tag, input logic [1:0] exp);
      @(negedge clk);
      #1;
      push(tag, 1'b1, {6'd0, exp});
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic set_pin(input int p, input logic v);
      @(negedge clk);
      pin_i[p] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_ack();
      @(negedge clk);
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      chk_reg("R1 sense reset", 2'd0, 8'h00);
      chk_reg("R1 enable reset", 2'd1, 8'h00);
      chk_reg("R1 pending reset", 2'd2, 8'h00);
      chk_irq("R1 irq reset", 2'b00);

      bus_wr(2'd1, 8'hFF);
      chk_reg("R7 enable reserved", 2'd1, 8'h03);
      bus_wr(2'd1, 8'h00);
      bus_wr(2'd2, 8'hFF);
      chk_reg("R7 pending not writable", 2'd2, 8'h00);

      // pin0 rise, pin1 any
      bus_wr(2'd0, 8'h07);
      chk_reg("R2 sense readback", 2'd0, 8'h07);
      set_pin(0, 1'b1);
      chk_reg("R2 rise sets", 2'd2, 8'h01);
      chk_irq("R8 masked no irq", 2'b00);
      bus_wr(2'd2, 8'h01);
      chk_reg("R6 w1c clears", 2'd2, 8'h00);
      set_pin(0, 1'b0);
      chk_reg("R2 fall ignored", 2'd2, 8'h00);

      set_pin(1, 1'b1);
      chk_reg("R4 rise on any", 2'd2, 8'h02);
      bus_wr(2'd2, 8'h00);
      chk_reg("R6 zero keeps", 2'd2, 8'h02);
      bus_wr(2'd2, 8'h02);
      chk_reg("R6 clear pin1", 2'd2, 8'h00);
      set_pin(1, 1'b0);
      chk_reg("R4 fall on any", 2'd2, 8'h02);

      // pin0 fall
      bus_wr(2'd0, 8'h06);
      set_pin(0, 1'b1);
      chk_reg("R3 rise ignored", 2'd2, 8'h02);
      set_pin(0, 1'b0);
      chk_reg("R3 fall sets", 2'd2, 8'h03);

      bus_wr(2'd1, 8'h03);
      chk_irq("R8 gie low no irq", 2'b00);
      @(negedge clk); gie_i = 1'b1;
      chk_irq("R9 pin0 first", 2'b01);
      pulse_ack();
      chk_reg("R11 ack clears pin0 only", 2'd2, 8'h02);
      chk_irq("R9 pin1 next", 2'b11);
      pulse_ack();
      chk_reg("R11 ack clears pin1", 2'd2, 8'h00);
      chk_irq("R8 none pending", 2'b00);

      // pin0 low level, pin currently low
      bus_wr(2'd0, 8'h04);
      chk_irq("R5 level request", 2'b01);
      chk_reg("R5 no latch", 2'd2, 8'h00);
      set_pin(0, 1'b1);
      chk_irq("R5 level released", 2'b00);
      set_pin(0, 1'b0);
      chk_irq("R5 level again", 2'b01);
      bus_wr(2'd1, 8'h02);
      chk_irq("R8 level masked", 2'b00);
      set_pin(0, 1'b1);
      chk_reg("R5 still no latch", 2'd2, 8'h00);

      // set wins over same-cycle clear: pin0 rise mode
      bus_wr(2'd0, 8'h07);
      set_pin(0, 1'b0);
      @(negedge clk);
      pin_i[0] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_addr = 2'd2; bus_wdata = 8'h01; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      chk_reg("R10 set beats clear", 2'd2, 8'h01);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule